// File: doc/BRIEF.md
# Interrupt Flag and Request Controller

This block gathers three single-cycle event pulses (periodic tick, alarm match and update-ended) into sticky flags. Software reads them as one status byte, and the read clears them. Each flag is also ANDed with its enable bit. The OR of those terms drives an open-drain style interrupt request, where a high `irq_drive_o` means the pad is pulled low. The same OR is reported as a summary flag in the top bit of the status byte.

The block also holds the control byte that carries the enables and the freeze bit. Writing the freeze bit as 1 forces the update enable off. A status read is a level strobe that may last several cycles. The flags stay frozen while the strobe is high and are cleared on the edge after it falls. Events that land during the read are parked in one pending bit per source and posted on the following edge, so none is lost.

Top module: `irq_flag_ctrl`

## Requirements
- R1: `status_o` holds the summary flag at bit 7, the periodic flag at bit 6, the alarm flag at bit 5 and the update flag at bit 4. Bits 3 to 0 always read 0.
- R2: An event pulse sampled on a clock edge outside a read sets its flag on that edge, whatever its enable bit holds.
- R3: `irq_drive_o` and `status_o[7]` are 1 exactly when at least one source has both its flag and its effective enable at 1.
- R4: Writing an enable bit to 1 while that source's flag is already 1 raises `irq_drive_o` on the same edge that stores the enable.
- R5: While `rd_strobe_i` is sampled high, the flags do not change, so `status_o` is stable for the whole read.
- R6: On the first edge at which `rd_strobe_i` is sampled low after being high, every flag and the summary flag clear to 0.
- R7: An event sampled while the strobe is high, or on the clearing edge, is held pending. It sets its flag on the next edge after the clearing edge.
- R8: Control byte layout: bit 7 freeze (SET), bit 6 periodic enable, bit 5 alarm enable, bit 4 update enable, bit 3 square-wave enable, bits 2:0 general bits. A write with bit 7 set stores the update enable as 0. The update source requests an interrupt only when its enable is 1 and freeze is 0.
- R9: A low `rst_n` on an edge clears all flags, pending bits and control bits 6:3, and releases `irq_drive_o`. Control bits 7 and 2:0 keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_periodic_i | input | 1 | Periodic tick event pulse |
| ev_alarm_i | input | 1 | Alarm match event pulse |
| ev_update_i | input | 1 | Update-ended event pulse |
| ctrl_we_i | input | 1 | Control byte write strobe |
| ctrl_wdata_i | input | 8 | Control byte write data |
| rd_strobe_i | input | 1 | Status read in progress (level) |
| status_o | output | 8 | Status byte |
| ctrl_o | output | 8 | Stored control byte |
| irq_drive_o | output | 1 | 1 = pull interrupt line low |

## Verification
Every result is due one edge after its stimulus is sampled. An event, a control write or the falling read strobe is seen in the flags, enables or cleared status after the edge that samples it. Pending events need a second edge after the clearing edge. The bench drives inputs just after a rising edge and reads outputs just after the next one, so each check falls in the cycle that is one register away from its cause. The sweep covers every enable pattern against every event pattern, with the expected request computed in the bench from the AND-OR rule.

// File: rtl/irq_flag_pkg.sv
// Shared constants for the interrupt flag controller.
// Assumes three sources, ordered periodic, alarm, update from MSB to LSB.
package irq_flag_pkg;
    localparam int NSRC     = 3;
    localparam int STAT_W   = 8;
    localparam int SRC_PER  = 2;
    localparam int SRC_ALM  = 1;
    localparam int SRC_UPD  = 0;
    localparam int CB_SET   = 7;
    localparam int CB_EN_LO = 4;
    localparam int CB_SQWE  = 3;
    localparam int CB_GP_W  = 3;
endpackage

// File: rtl/irq_flag_cell.sv
// One interrupt source: a sticky flag plus a pending bit that parks events
// arriving during a status read. Assumes hold_i and clear_i are never both 1.
module irq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_i,
    input  logic hold_i,
    input  logic clear_i,
    output logic flag_o
);
    logic flag_q;
    logic pend_q;

    // Flag and pending update: freeze during read, clear after, then merge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (hold_i) begin
            pend_q <= pend_q | ev_i;
        end else if (clear_i) begin
            flag_q <= 1'b0;
            pend_q <= pend_q | ev_i;
        end else begin
            flag_q <= flag_q | ev_i | pend_q;
            pend_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;

    p_set_on_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i && !hold_i && !clear_i) |=> flag_q);
    p_frozen_in_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(flag_q));
    p_cleared_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !flag_q);
    p_pending_posted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !hold_i && !clear_i) |=> flag_q);
endmodule

// File: rtl/irq_ctrl_reg.sv
// Control byte holding freeze, per-source enables, square-wave enable and
// general bits. Reset clears only the enable bits; freeze and general bits
// keep their value. A write with freeze set forces the update enable to 0.
module irq_ctrl_reg
    import irq_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [STAT_W-1:0] wdata_i,
    output logic [STAT_W-1:0] ctrl_o,
    output logic [NSRC-1:0]   en_eff_o
);
    logic              set_q;
    logic [NSRC-1:0]   en_q;
    logic              sqwe_q;
    logic [CB_GP_W-1:0] gp_q;

    // Resettable enables; a freeze write suppresses the update enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            sqwe_q <= 1'b0;
        end else if (we_i) begin
            en_q   <= wdata_i[CB_EN_LO +: NSRC] &
                      ~(NSRC'(wdata_i[CB_SET]) << SRC_UPD);
            sqwe_q <= wdata_i[CB_SQWE];
        end
    end

    // Bits untouched by reset: freeze and general-purpose bits.
    always_ff @(posedge clk) begin
        if (we_i && rst_n) begin
            set_q <= wdata_i[CB_SET];
            gp_q  <= wdata_i[CB_GP_W-1:0];
        end
    end

    assign ctrl_o   = {set_q, en_q, sqwe_q, gp_q};
    assign en_eff_o = en_q & ~(NSRC'(set_q) << SRC_UPD);

    p_freeze_kills_upd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && wdata_i[CB_SET]) |=> !en_q[SRC_UPD]);
    p_reset_enables_r9: assert property (@(posedge clk)
        !rst_n |=> (en_q == '0 && !sqwe_q));
endmodule

// File: rtl/irq_flag_ctrl.sv
// Interrupt flag and request controller top. Collects event pulses into
// clear-on-read flags, gates them with enables and drives the request.
// Assumes rd_strobe_i is a level held high for the whole status read.
module irq_flag_ctrl
    import irq_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_periodic_i,
    input  logic              ev_alarm_i,
    input  logic              ev_update_i,
    input  logic              ctrl_we_i,
    input  logic [STAT_W-1:0] ctrl_wdata_i,
    input  logic              rd_strobe_i,
    output logic [STAT_W-1:0] status_o,
    output logic [STAT_W-1:0] ctrl_o,
    output logic              irq_drive_o
);
    localparam int LOW_W = STAT_W - 1 - NSRC;

    logic            rd_q;
    logic            rd_clear;
    logic [NSRC-1:0] ev_vec;
    logic [NSRC-1:0] flags;
    logic [NSRC-1:0] en_eff;
    logic            irqf;

    // Track the read strobe to find its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= rd_strobe_i;
    end

    assign rd_clear = rd_q && !rd_strobe_i;
    assign ev_vec   = {ev_periodic_i, ev_alarm_i, ev_update_i};

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        irq_flag_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .ev_i    (ev_vec[i]),
            .hold_i  (rd_strobe_i),
            .clear_i (rd_clear),
            .flag_o  (flags[i])
        );
    end

    irq_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (ctrl_we_i),
        .wdata_i  (ctrl_wdata_i),
        .ctrl_o   (ctrl_o),
        .en_eff_o (en_eff)
    );

    assign irqf        = |(flags & en_eff);
    assign irq_drive_o = irqf;
    assign status_o    = {irqf, flags, {LOW_W{1'b0}}};

    p_low_bits_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[LOW_W-1:0] == '0);
    p_irq_needs_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_drive_o |-> (status_o[STAT_W-2 -: NSRC] != '0));
    p_irq_released_r9: assert property (@(posedge clk)
        !rst_n |=> !irq_drive_o);
endmodule

// File: tb/irq_flag_ctrl_bench.sv
module irq_flag_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evp = 0, eva = 0, evu = 0;
    logic       we = 0;
    logic [7:0] wd = '0;
    logic       rd = 0;
    logic [7:0] status;
    logic [7:0] ctrl;
    logic       irq;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    irq_flag_ctrl u_irq_flag_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ev_periodic_i(evp), .ev_alarm_i(eva), .ev_update_i(evu),
        .ctrl_we_i(we), .ctrl_wdata_i(wd), .rd_strobe_i(rd),
        .status_o(status), .ctrl_o(ctrl), .irq_drive_o(irq)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] d);
        we = 1; wd = d; step(); we = 0;
    endtask

    task automatic pulse(input logic [2:0] e);
        {evp, eva, evu} = e; step(); {evp, eva, evu} = '0;
    endtask

    task automatic do_read(); // full read; flags clear on the falling edge
        rd = 1; step(); step(); rd = 0; step();
    endtask

    function automatic logic [7:0] exp_stat(input logic [2:0] f, input logic [7:0] c);
        logic [2:0] en;
        en = {c[6], c[5], c[4] & ~c[7]};
        return {|(f & en), f, 4'b0};
    endfunction

    initial begin
        repeat (3) step();
        rst_n = 1;
        // R1 R9: reset state
        chk("R1 reset status", {1'b0, status}, 9'h000);
        chk("R9 reset irq", {8'h0, irq}, 9'h000);
        // R8: freeze write drops update enable
        wr_ctrl(8'hFF);
        chk("R8 freeze clears uie", {1'b0, ctrl}, {1'b0, 8'hEF});
        wr_ctrl(8'h70);
        // R2 R3 R1 sweep: every enable pattern x every event pattern
        for (int c = 0; c < 16; c++) begin
            for (int e = 1; e < 8; e++) begin
                logic [7:0] cv;
                cv = {c[3], c[2:0], 4'b0};
                wr_ctrl(cv);
                pulse(e[2:0]);
                chk("R2 flags set", {1'b0, status & 8'h70}, {1'b0, 1'b0, e[2:0], 4'b0});
                chk("R3 status/irqf", {1'b0, status}, {1'b0, exp_stat(e[2:0], cv)});
                chk("R3 irq pin", {8'h0, irq}, {8'h0, exp_stat(e[2:0], cv) >> 7});
                do_read();
                chk("R6 cleared", {1'b0, status}, 9'h000);
            end
        end
        // R4: enable after flag already set
        wr_ctrl(8'h00);
        pulse(3'b010);
        chk("R4 no irq yet", {8'h0, irq}, 9'h000);
        wr_ctrl(8'h20);
        chk("R4 irq on enable", {8'h0, irq}, 9'h001);
        do_read();
        // R8: update source gated by freeze even though enable written later
        wr_ctrl(8'h10);
        pulse(3'b001);
        chk("R8 uie irq", {8'h0, irq}, 9'h001);
        wr_ctrl(8'h90);
        chk("R8 set masks update", {1'b0, status}, {1'b0, 8'h10});
        do_read();
        // R5 R6 R7: events during read
        wr_ctrl(8'h70);
        pulse(3'b100);
        rd = 1; step();
        chk("R5 snapshot", {1'b0, status}, {1'b0, 8'hC0});
        {evp, eva, evu} = 3'b011; step(); {evp, eva, evu} = 0;
        chk("R5 stable in read", {1'b0, status}, {1'b0, 8'hC0});
        rd = 0; evp = 1; step(); evp = 0;
        chk("R6 clear after read", {1'b0, status}, 9'h000);
        step();
        chk("R7 pending posted", {1'b0, status}, {1'b0, 8'hF0});
        do_read();
        // R9: reset clears flags/enables, keeps freeze and low bits
        wr_ctrl(8'hFF);
        pulse(3'b111);
        rst_n = 0; step(); rst_n = 1;
        chk("R9 flags cleared", {1'b0, status}, 9'h000);
        chk("R9 ctrl kept bits", {1'b0, ctrl}, {1'b0, 8'h87});
        chk("R9 irq released", {8'h0, irq}, 9'h000);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule